// File: doc/BRIEF.md
# Three-Wire Serial Clock-Chip Master

This block drives a three-line serial link to a real-time-clock device: an enable line, a serial clock and one shared data line. The data line is driven through an output enable and read back through a separate input pin. A host hands over a command byte, a direction flag and a byte count on a valid/ready port. The block then opens an enable window and shifts the command out. For a write it streams the host's data bytes on a second valid/ready port. For a read it releases the data line and delivers the bytes it samples as single-cycle pulses on a read stream.

All link timing comes from parameters. `PHASE_CYC` system clocks form one serial clock phase, high or low. The setup gap between enable rising and the first clock pulse lasts `SETUP_PHASES` phases. One command can move any number of bytes from 1 to `MAX_BYTES` inside a single enable window. This covers both single-register access and burst access, such as an 8-byte clock write, a 7-byte clock read or a RAM burst. The input is resynchronised through `SYNC_STAGES` flops before it is sampled.

Top module: `tw_rtc_master`

## Requirements
- R1: Every byte on the link, command or data, takes exactly eight serial clock pulses, least-significant bit first. A transfer of N data bytes makes 8*(N+1) pulses in total.
- R2: The serial clock is low whenever the enable line is low, and it is low in the cycle that enable rises.
- R3: From enable rising to the first clock rise there are exactly PHASE_CYC*SETUP_PHASES cycles. Every high phase lasts exactly PHASE_CYC cycles, and no low phase between pulses is shorter than PHASE_CYC cycles.
- R4: The command byte sent on the link equals the host byte with bit 0 replaced by the direction flag: 1 for a read, 0 for a write.
- R5: For a read, the output enable is low at every clock rise after the command byte. Bits are sampled at the end of each low phase. The N sampled bytes appear on rd_data in link order, with rd_last set only on the N-th byte.
- R6: For a write, the N bytes taken on the write port, handshaken with wr_valid and wr_ready, are sent in order after the command. While the host withholds data, the serial clock stays low.
- R7: Enable stays high through the whole transfer and falls exactly PHASE_CYC cycles after the last falling clock edge. Each accepted command produces exactly one enable window.
- R8: While the output enable is high, the data line changes only in cycles where the serial clock is low.
- R9: A command with a byte count of zero is consumed, raises err for exactly one cycle and opens no enable window.
- R10: busy is high from the cycle after a command is accepted until enable falls. cmd_ready is high only while the block is idle.
- R11: A synchronous reset, even in mid-transfer, drives enable low, the serial clock low and the output enable low. After it, busy is low and cmd_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Host offers a command |
| cmd_ready | output | 1 | Block is idle and takes a command |
| cmd_byte | input | 8 | Command byte; bit 0 is overwritten |
| cmd_read | input | 1 | 1 = read transfer, 0 = write transfer |
| cmd_count | input | CNT_W | Number of data bytes, 1..MAX_BYTES |
| wr_valid | input | 1 | Host offers a write data byte |
| wr_ready | output | 1 | Block takes the next write byte |
| wr_data | input | 8 | Write data byte |
| rd_valid | output | 1 | One-cycle pulse: a read byte is present |
| rd_data | output | 8 | Read byte |
| rd_last | output | 1 | Marks the final read byte |
| busy | output | 1 | Transfer in progress |
| err | output | 1 | One-cycle pulse: zero-count command refused |
| rtc_ce | output | 1 | Link enable |
| rtc_sclk | output | 1 | Link serial clock |
| rtc_dio_o | output | 1 | Data line drive value |
| rtc_dio_oe | output | 1 | Data line output enable |
| rtc_dio_i | input | 1 | Data line input sample |

## Verification
The in-line properties watch the link rules on every cycle: the clock stays low around enable edges, the data line is quiet while the clock is high, the line is released and busy while read bytes are delivered, and zero-count refusals never open a window. The properties also check the post-reset state and that the shifter performs at most one operation per cycle. Only the bench scenarios can show the counted behaviour. This covers exact setup and phase lengths, the number of pulses per transfer, the command bit-0 rewrite and LSB-first order, byte contents and the last marker across every count from 1 to 31, write stalls, and recovery from a reset in mid-transfer.

// File: rtl/tw_pkg.sv
package tw_pkg;

   localparam int BYTE_W = 8;
   localparam int BIT_W  = $clog2(BYTE_W);

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SETUP,
      ST_HIGH,
      ST_LOW,
      ST_LOAD,
      ST_END
   } tw_state_e;

   // Command byte as it goes on the link: direction replaces bit 0.
   function automatic logic [BYTE_W-1:0] link_cmd(input logic [BYTE_W-1:0] c,
                                                  input logic rd);
      return {c[BYTE_W-1:1], rd};
   endfunction

endpackage

// File: rtl/tw_phase_timer.sv
module tw_phase_timer #(
   parameter int TMR_W = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             restart,
   input  logic [TMR_W-1:0] len,
   output logic             expire
);

   logic [TMR_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst)
         cnt_q <= '0;
      else if (restart)
         cnt_q <= len - TMR_W'(1);
      else if (cnt_q != '0)
         cnt_q <= cnt_q - TMR_W'(1);
   end

   assign expire = (cnt_q == '0);

   // R3: a phase of zero length would collapse a timed interval
   p_len_nonzero_r3: assert property (@(posedge clk) disable iff (rst)
      restart |-> (len != '0));

endmodule

// File: rtl/tw_shifter.sv
module tw_shifter #(
   parameter int WIDTH       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [WIDTH-1:0] load_val,
   input  logic             shift_out,
   input  logic             shift_in,
   input  logic             din,
   output logic             dout,
   output logic [WIDTH-1:0] word
);

   logic din_s;
   logic [WIDTH-1:0] sh_q;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign din_s = din;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sq;
         always_ff @(posedge clk) begin
            if (rst) begin
               sq <= '0;
            end else begin
               sq[0] <= din;
               for (int i = 1; i < SYNC_STAGES; i++)
                  sq[i] <= sq[i-1];
            end
         end
         assign din_s = sq[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)
         sh_q <= '0;
      else if (load)
         sh_q <= load_val;
      else if (shift_out)
         sh_q <= {1'b0, sh_q[WIDTH-1:1]};
      else if (shift_in)
         sh_q <= {din_s, sh_q[WIDTH-1:1]};
   end

   assign dout = sh_q[0];
   assign word = sh_q;

   // R1: the sequencer asks for at most one shifter operation per cycle
   p_one_op_r1: assert property (@(posedge clk) disable iff (rst)
      $onehot0({load, shift_out, shift_in}));

endmodule

// File: rtl/tw_seq.sv
module tw_seq
   import tw_pkg::*;
#(
   parameter int PHASE_CYC = 4,
   parameter int SETUP_CYC = 16,
   parameter int CNT_W     = 5,
   parameter int TMR_W     = 5
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic [BYTE_W-1:0] cmd_byte,
   input  logic              cmd_read,
   input  logic [CNT_W-1:0]  cmd_count,
   input  logic              wr_valid,
   output logic              wr_ready,
   input  logic [BYTE_W-1:0] wr_data,
   output logic              rd_valid,
   output logic [BYTE_W-1:0] rd_data,
   output logic              rd_last,
   output logic              busy,
   output logic              err,
   output logic              ce,
   output logic              sclk,
   output logic              oe,
   input  logic              dio,
   output logic              tmr_restart,
   output logic [TMR_W-1:0]  tmr_len,
   input  logic              tmr_expire,
   output logic              sh_load,
   output logic [BYTE_W-1:0] sh_load_val,
   output logic              sh_out,
   output logic              sh_in,
   input  logic [BYTE_W-1:0] sh_word
);

   tw_state_e         state_q, state_n;
   logic [BIT_W-1:0]  bit_q, bit_n;
   logic [CNT_W-1:0]  rem_q, rem_n;
   logic              rdm_q, rdm_n;   // transfer is a read
   logic              dat_q, dat_n;   // command byte already sent
   logic              oe_q, oe_n;
   logic              ce_q, sclk_q;
   logic              rdv_q, rdv_n;
   logic [BYTE_W-1:0] rdd_q;
   logic              rdl_q;
   logic              err_q, err_n;
   logic              last_byte;

   assign last_byte = (rem_q == CNT_W'(1));
   assign cmd_ready = (state_q == ST_IDLE);
   assign wr_ready  = (state_q == ST_LOAD);

   always_comb begin
      state_n     = state_q;
      bit_n       = bit_q;
      rem_n       = rem_q;
      rdm_n       = rdm_q;
      dat_n       = dat_q;
      oe_n        = oe_q;
      rdv_n       = 1'b0;
      err_n       = 1'b0;
      tmr_restart = 1'b0;
      tmr_len     = TMR_W'(PHASE_CYC);
      sh_load     = 1'b0;
      sh_load_val = '0;
      sh_out      = 1'b0;
      sh_in       = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (cmd_valid) begin
               if (cmd_count == '0) begin
                  err_n = 1'b1;
               end else begin
                  state_n     = ST_SETUP;
                  tmr_restart = 1'b1;
                  tmr_len     = TMR_W'(SETUP_CYC);
                  sh_load     = 1'b1;
                  sh_load_val = link_cmd(cmd_byte, cmd_read);
                  bit_n       = '0;
                  rem_n       = cmd_count;
                  rdm_n       = cmd_read;
                  dat_n       = 1'b0;
                  oe_n        = 1'b1;
               end
            end
         end
         ST_SETUP: begin
            if (tmr_expire) begin
               state_n     = ST_HIGH;
               tmr_restart = 1'b1;
            end
         end
         ST_HIGH: begin
            if (tmr_expire) begin
               tmr_restart = 1'b1;
               bit_n       = bit_q + BIT_W'(1);
               if (bit_q == BIT_W'(BYTE_W - 1)) begin
                  if (!dat_q) begin
                     dat_n   = 1'b1;
                     oe_n    = !rdm_q;
                     state_n = rdm_q ? ST_LOW : ST_LOAD;
                  end else begin
                     rem_n   = rem_q - CNT_W'(1);
                     rdv_n   = rdm_q;
                     if (last_byte)
                        state_n = ST_END;
                     else
                        state_n = rdm_q ? ST_LOW : ST_LOAD;
                  end
               end else begin
                  state_n = ST_LOW;
                  sh_out  = !(dat_q && rdm_q);
               end
            end
         end
         ST_LOW: begin
            if (tmr_expire) begin
               state_n     = ST_HIGH;
               tmr_restart = 1'b1;
               sh_in       = dat_q && rdm_q;
            end
         end
         ST_LOAD: begin
            if (wr_valid) begin
               state_n     = ST_LOW;
               tmr_restart = 1'b1;
               sh_load     = 1'b1;
               sh_load_val = wr_data;
            end
         end
         ST_END: begin
            if (tmr_expire)
               state_n = ST_IDLE;
         end
         default: state_n = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_IDLE;
         bit_q   <= '0;
         rem_q   <= '0;
         rdm_q   <= 1'b0;
         dat_q   <= 1'b0;
         oe_q    <= 1'b0;
         ce_q    <= 1'b0;
         sclk_q  <= 1'b0;
         rdv_q   <= 1'b0;
         rdd_q   <= '0;
         rdl_q   <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         state_q <= state_n;
         bit_q   <= bit_n;
         rem_q   <= rem_n;
         rdm_q   <= rdm_n;
         dat_q   <= dat_n;
         oe_q    <= (state_n == ST_IDLE) ? 1'b0 : oe_n;
         ce_q    <= (state_n != ST_IDLE);
         sclk_q  <= (state_n == ST_HIGH);
         rdv_q   <= rdv_n;
         err_q   <= err_n;
         if (rdv_n) begin
            rdd_q <= sh_word;
            rdl_q <= last_byte;
         end
      end
   end

   assign ce       = ce_q;
   assign sclk     = sclk_q;
   assign oe       = oe_q;
   assign busy     = ce_q;
   assign rd_valid = rdv_q;
   assign rd_data  = rdd_q;
   assign rd_last  = rdl_q;
   assign err      = err_q;

   // R2: the serial clock is low when the enable window opens
   p_ce_rise_clk_low_r2: assert property (@(posedge clk) disable iff (rst)
      $rose(ce_q) |-> !sclk_q);

   // R3: no clock pulse begins in the same cycle the window opens
   p_clk_after_ce_r3: assert property (@(posedge clk) disable iff (rst)
      $rose(sclk_q) |-> $past(ce_q));

   // R7: the window closes only after a low phase
   p_ce_fall_after_low_r7: assert property (@(posedge clk) disable iff (rst)
      $fell(ce_q) |-> $past(!sclk_q));

   // R8: a driven data line is quiet while the clock is high
   p_dio_quiet_high_r8: assert property (@(posedge clk) disable iff (rst)
      (oe_q && !$stable(dio)) |-> !sclk_q);

   // R5: read bytes surface only inside a window with the line released
   p_rd_inside_r5: assert property (@(posedge clk) disable iff (rst)
      rdv_q |-> (ce_q && !oe_q));

   // R9: a refused command never opens a window
   p_err_no_window_r9: assert property (@(posedge clk) disable iff (rst)
      err_q |-> !ce_q);

   // R10: commands are taken only while nothing is in flight
   p_ready_idle_r10: assert property (@(posedge clk) disable iff (rst)
      cmd_ready |-> !busy);

   // R11: the cycle after reset shows a closed, quiet link
   p_reset_quiet_r11: assert property (@(posedge clk)
      $past(rst) |-> (!ce_q && !sclk_q && !oe_q && !rdv_q));

endmodule

// File: rtl/tw_rtc_master.sv
module tw_rtc_master
   import tw_pkg::*;
#(
   parameter  int PHASE_CYC    = 4,
   parameter  int SETUP_PHASES = 4,
   parameter  int SYNC_STAGES  = 2,
   parameter  int MAX_BYTES    = 31,
   localparam int CNT_W        = $clog2(MAX_BYTES + 1)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic [7:0]        cmd_byte,
   input  logic              cmd_read,
   input  logic [CNT_W-1:0]  cmd_count,
   input  logic              wr_valid,
   output logic              wr_ready,
   input  logic [7:0]        wr_data,
   output logic              rd_valid,
   output logic [7:0]        rd_data,
   output logic              rd_last,
   output logic              busy,
   output logic              err,
   output logic              rtc_ce,
   output logic              rtc_sclk,
   output logic              rtc_dio_o,
   output logic              rtc_dio_oe,
   input  logic              rtc_dio_i
);

   localparam int SETUP_CYC = PHASE_CYC * SETUP_PHASES;
   localparam int TMR_W     = $clog2(SETUP_CYC + 1);

   generate
      if (PHASE_CYC <= SYNC_STAGES) begin : g_bad_phase
         $error("PHASE_CYC must exceed SYNC_STAGES");
      end
      if (SETUP_PHASES < 1) begin : g_bad_setup
         $error("SETUP_PHASES must be at least 1");
      end
      if (MAX_BYTES < 1) begin : g_bad_max
         $error("MAX_BYTES must be at least 1");
      end
   endgenerate

   logic              tmr_restart, tmr_expire;
   logic [TMR_W-1:0]  tmr_len;
   logic              sh_load, sh_out, sh_in;
   logic [BYTE_W-1:0] sh_load_val, sh_word;

   tw_phase_timer #(.TMR_W(TMR_W)) u_timer (
      .clk     (clk),
      .rst     (rst),
      .restart (tmr_restart),
      .len     (tmr_len),
      .expire  (tmr_expire)
   );

   tw_shifter #(.WIDTH(BYTE_W), .SYNC_STAGES(SYNC_STAGES)) u_shift (
      .clk       (clk),
      .rst       (rst),
      .load      (sh_load),
      .load_val  (sh_load_val),
      .shift_out (sh_out),
      .shift_in  (sh_in),
      .din       (rtc_dio_i),
      .dout      (rtc_dio_o),
      .word      (sh_word)
   );

   tw_seq #(
      .PHASE_CYC (PHASE_CYC),
      .SETUP_CYC (SETUP_CYC),
      .CNT_W     (CNT_W),
      .TMR_W     (TMR_W)
   ) u_seq (
      .clk         (clk),
      .rst         (rst),
      .cmd_valid   (cmd_valid),
      .cmd_ready   (cmd_ready),
      .cmd_byte    (cmd_byte),
      .cmd_read    (cmd_read),
      .cmd_count   (cmd_count),
      .wr_valid    (wr_valid),
      .wr_ready    (wr_ready),
      .wr_data     (wr_data),
      .rd_valid    (rd_valid),
      .rd_data     (rd_data),
      .rd_last     (rd_last),
      .busy        (busy),
      .err         (err),
      .ce          (rtc_ce),
      .sclk        (rtc_sclk),
      .oe          (rtc_dio_oe),
      .dio         (rtc_dio_o),
      .tmr_restart (tmr_restart),
      .tmr_len     (tmr_len),
      .tmr_expire  (tmr_expire),
      .sh_load     (sh_load),
      .sh_load_val (sh_load_val),
      .sh_out      (sh_out),
      .sh_in       (sh_in),
      .sh_word     (sh_word)
   );

endmodule

// File: tb/tw_rtc_master_tb.sv
module tw_rtc_master_tb;

   localparam int CLK_PER  = 10;
   localparam int PHASE    = 4;
   localparam int SMULT    = 4;
   localparam int SETUP    = PHASE * SMULT;
   localparam int MAXB     = 31;
   localparam int CW       = $clog2(MAXB + 1);
   localparam int WDOG     = 180000;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic cmd_valid = 1'b0, cmd_read = 1'b0, wr_valid = 1'b0;
   logic [7:0] cmd_byte = '0, wr_data = '0;
   logic [CW-1:0] cmd_count = '0;
   logic cmd_ready, wr_ready, rd_valid, rd_last, busy, err;
   logic [7:0] rd_data;
   logic rtc_ce, rtc_sclk, rtc_dio_o, rtc_dio_oe;
   logic dev_drive = 1'b0;

   always #(CLK_PER/2) clk = ~clk;

   tw_rtc_master #(.PHASE_CYC(PHASE), .SETUP_PHASES(SMULT), .SYNC_STAGES(2),
                   .MAX_BYTES(MAXB)) u_dut (
      .clk(clk), .rst(rst),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_byte(cmd_byte),
      .cmd_read(cmd_read), .cmd_count(cmd_count),
      .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
      .rd_valid(rd_valid), .rd_data(rd_data), .rd_last(rd_last),
      .busy(busy), .err(err),
      .rtc_ce(rtc_ce), .rtc_sclk(rtc_sclk), .rtc_dio_o(rtc_dio_o),
      .rtc_dio_oe(rtc_dio_oe), .rtc_dio_i(dev_drive)
   );

   int n_checks = 0;
   int n_errs   = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_errs++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // ---------------- device model and link monitor ----------------
   logic [7:0] dev_mem [0:31];
   logic [7:0] rx_bytes [0:63];
   logic [7:0] rd_got [0:63];
   logic       rd_lastf [0:63];
   logic [7:0] dev_cmd = '0, shv = '0;
   logic p_ce = 0, p_sclk = 0, p_oe = 0, p_dio = 0;
   int setup_cnt = 0, hi_len = 0, lo_len = 0, bad_hi = 0, bad_lo = 0;
   int dio_bad = 0, oe_bad = 0, rises = 0, bitn = 0, rx_n = 0, rd_n = 0;
   int tx_bit = 0, dev_addr = 0, ce_falls = 0, end_gap = 0;
   int idle_sclk_bad = 0, rise_sclk_bad = 0;
   bit first_rise = 0, in_data = 0, dev_rd = 0;

   always @(negedge clk) begin
      if (!rtc_ce && rtc_sclk) idle_sclk_bad++;
      if (rtc_ce && !p_ce) begin
         if (rtc_sclk) rise_sclk_bad++;
         setup_cnt = 0; first_rise = 0; hi_len = 0; lo_len = 0;
         bad_hi = 0; bad_lo = 0; dio_bad = 0; oe_bad = 0; rises = 0;
         bitn = 0; rx_n = 0; rd_n = 0; in_data = 0; dev_rd = 0; tx_bit = 0;
      end
      if (!rtc_ce && p_ce) begin
         ce_falls++;
         end_gap = lo_len;
      end
      if (rtc_ce) begin
         if (rtc_dio_oe && p_oe && (rtc_dio_o != p_dio) && rtc_sclk) dio_bad++;
         if (!first_rise && !rtc_sclk) setup_cnt++;
         if (rtc_sclk) hi_len++;
         if (rtc_sclk && !p_sclk) begin
            if (first_rise && lo_len < PHASE) bad_lo++;
            first_rise = 1; lo_len = 0; rises++;
            if (!in_data || !dev_rd) begin
               if (!rtc_dio_oe) oe_bad++;
               shv[bitn] = rtc_dio_o;
               bitn++;
               if (bitn == 8) begin
                  bitn = 0;
                  if (!in_data) begin
                     dev_cmd  = shv;
                     dev_rd   = shv[0];
                     dev_addr = (shv[5:1] == 5'h1F) ? 0 : int'(shv[5:1]);
                     in_data  = 1;
                  end else begin
                     rx_bytes[rx_n] = shv;
                     rx_n++;
                  end
               end
            end else if (rtc_dio_oe) begin
               oe_bad++;
            end
         end
         if (!rtc_sclk && p_sclk) begin
            if (hi_len != PHASE) bad_hi++;
            hi_len = 0; lo_len = 0;
            if (in_data && dev_rd) begin
               dev_drive = dev_mem[dev_addr][tx_bit];
               if (tx_bit == 7) begin
                  tx_bit = 0;
                  dev_addr = (dev_addr + 1) % 32;
               end else begin
                  tx_bit++;
               end
            end
         end
         if (!rtc_sclk && first_rise) lo_len++;
      end
      if (rd_valid) begin
         rd_got[rd_n]   = rd_data;
         rd_lastf[rd_n] = rd_last;
         rd_n++;
      end
      p_ce = rtc_ce; p_sclk = rtc_sclk; p_oe = rtc_dio_oe; p_dio = rtc_dio_o;
   end

   // ---------------- stimulus ----------------
   function automatic logic [7:0] wdat(input int k, input int n);
      return 8'((k * 29 + n * 7 + 3) & 255);
   endfunction

   task automatic send_cmd(input logic [7:0] c, input logic rd, input int n);
      while (!cmd_ready) @(negedge clk);
      cmd_byte = c; cmd_read = rd; cmd_count = CW'(n); cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic feed_writes(input int n, input int stall);
      for (int k = 0; k < n; k++) begin
         while (!wr_ready) @(negedge clk);
         repeat (stall) begin
            @(negedge clk);
            chk(!rtc_sclk, "R6 clock low during stall", int'(rtc_sclk), 0);
         end
         wr_valid = 1'b1; wr_data = wdat(k, n);
         @(negedge clk);
         wr_valid = 1'b0;
      end
   endtask

   task automatic run_txn(input logic [7:0] c, input logic rd, input int n, input int stall);
      int falls0;
      int addr;
      falls0 = ce_falls;
      addr = (c[5:1] == 5'h1F) ? 0 : int'(c[5:1]);
      send_cmd(c, rd, n);
      chk(busy == 1'b1, "R10 busy after accept", int'(busy), 1);
      chk(cmd_ready == 1'b0, "R10 ready low while busy", int'(cmd_ready), 0);
      if (!rd) feed_writes(n, stall);
      while (rtc_ce) @(negedge clk);
      @(negedge clk);
      chk(busy == 1'b0, "R10 busy low after window", int'(busy), 0);
      chk(dev_cmd == {c[7:1], rd}, "R4 command bit0", int'(dev_cmd), int'({c[7:1], rd}));
      chk(setup_cnt == SETUP, "R3 setup cycles", setup_cnt, SETUP);
      chk(bad_hi == 0, "R3 high phase length", bad_hi, 0);
      chk(bad_lo == 0, "R3 low phase length", bad_lo, 0);
      chk(rises == 8 * (n + 1), "R1 pulse count", rises, 8 * (n + 1));
      chk(dio_bad == 0, "R8 data change while clock high", dio_bad, 0);
      chk(end_gap == PHASE, "R7 enable drop delay", end_gap, PHASE);
      chk(ce_falls == falls0 + 1, "R7 single window", ce_falls - falls0, 1);
      chk(rise_sclk_bad == 0 && idle_sclk_bad == 0, "R2 clock low around enable",
          rise_sclk_bad + idle_sclk_bad, 0);
      if (rd) begin
         chk(oe_bad == 0, "R5 line released for read", oe_bad, 0);
         chk(rd_n == n, "R5 read byte count", rd_n, n);
         for (int k = 0; k < n && k < rd_n; k++) begin
            chk(rd_got[k] == dev_mem[(addr + k) % 32], "R5 read data",
                int'(rd_got[k]), int'(dev_mem[(addr + k) % 32]));
            chk(rd_lastf[k] == (k == n - 1), "R5 last flag",
                int'(rd_lastf[k]), int'(k == n - 1));
         end
      end else begin
         chk(oe_bad == 0, "R6 line driven for write", oe_bad, 0);
         chk(rx_n == n, "R6 write byte count", rx_n, n);
         for (int k = 0; k < n && k < rx_n; k++)
            chk(rx_bytes[k] == wdat(k, n), "R1 R6 write data LSB first",
                int'(rx_bytes[k]), int'(wdat(k, n)));
      end
   endtask

   initial begin
      for (int i = 0; i < 32; i++) dev_mem[i] = 8'((i * 53 + 17) & 255);
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R11 reset state
      chk(!rtc_ce && !rtc_sclk && !rtc_dio_oe, "R11 link quiet after reset",
          int'({rtc_ce, rtc_sclk, rtc_dio_oe}), 0);
      chk(!busy && cmd_ready, "R11 idle after reset", int'({busy, cmd_ready}), 1);

      // R9 zero count
      send_cmd(8'h82, 1'b0, 0);
      chk(err == 1'b1, "R9 error pulse", int'(err), 1);
      chk(rtc_ce == 1'b0, "R9 no window", int'(rtc_ce), 0);
      @(negedge clk);
      chk(err == 1'b0, "R9 error one cycle", int'(err), 0);
      repeat (20) @(negedge clk);
      chk(rtc_ce == 1'b0 && rises == 0, "R9 link untouched", rises, 0);

      // Burst forms: clock write of 8, clock read of 7, RAM bursts
      run_txn(8'hBF, 1'b0, 8, 1);
      run_txn(8'hBE, 1'b1, 7, 0);
      run_txn(8'hFF, 1'b0, 5, 0);
      run_txn(8'hFE, 1'b1, 31, 0);

      // Sweep all counts, both directions, opposite host bit 0
      for (int n = 1; n <= MAXB; n++) begin
         logic [7:0] a;
         a = 8'(n % 31);
         run_txn(8'h80 | (a << 1) | 8'h01, 1'b0, n, n % 3);
         run_txn(8'h80 | (a << 1), 1'b1, n, 0);
      end

      // R11 reset mid-transfer
      send_cmd(8'h84, 1'b1, 5);
      repeat (100) @(negedge clk);
      chk(rtc_ce == 1'b1, "R11 window open before reset", int'(rtc_ce), 1);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk(!rtc_ce && !rtc_sclk && !rtc_dio_oe, "R11 link quiet after mid reset",
          int'({rtc_ce, rtc_sclk, rtc_dio_oe}), 0);
      chk(!busy && cmd_ready, "R11 idle after mid reset", int'({busy, cmd_ready}), 1);
      @(negedge clk);
      run_txn(8'h86, 1'b1, 2, 0);

      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
      $finish;
   end

   initial begin
      repeat (WDOG) @(posedge clk);
      n_checks++;
      n_errs++;
      $display("FAIL watchdog: actual %0d expected %0d", WDOG, 0);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
      $finish;
   end

endmodule